// File: doc/BRIEF.md
# Receiver Lock Acquisition Controller

This controller steps a serial receiver's clock recovery from frequency acquisition on a local reference clock to phase tracking of the incoming data stream. At reset it selects the reference clock as the recovery input and puts the detector in frequency mode. When the recovery loop reports frequency lock, the controller declares lock, switches the detector to phase mode and moves the input to the data stream, all from one state change.

Phase lock may settle on the wrong transition inside the frame. A frame is counted as bad when the boundary check reports misalignment. It is also counted as bad when flag checking is on and the flag bit fails to alternate from the previous frame. A run of `ERR_LIMIT` bad frames in a row (two by default) drops lock and sends the loop back to reference-clock acquisition. The hunt repeats until frames arrive clean. A loss-of-signal input drops lock at once. A saturating counter reports how many times lock has been dropped.

Top module: `rxlk_ctrl`

## Requirements
- R1: While reset is asserted and after it, until frequency lock is seen, `locked_o`, `phase_mode_o` and `src_data_o` are 0 and `retry_cnt_o` is 0.
- R2: If `freq_lock_i` is high at a clock edge while unlocked, then after that edge `locked_o`, `phase_mode_o` and `src_data_o` are all 1. While locked, `freq_lock_i` has no effect.
- R3: With `flag_chk_en_i` = 1, a valid frame whose `flag_i` equals the flag of the previous valid frame in the same lock period counts as a frame error. The first frame after lock has no predecessor. With `flag_chk_en_i` = 0, the flag is ignored.
- R4: A valid frame with `bound_err_i` = 1 is a frame error. Two consecutive frame errors (ERR_LIMIT = 2) drop lock at the edge of the second one.
- R5: A single frame error that is followed by a good frame does not drop lock.
- R6: The consecutive-error count clears on every good frame and on every drop into acquisition, so one error after a relock does not drop lock.
- R7: Frames are evaluated only when `frame_vld_i` = 1 and the controller is locked. Error inputs on other cycles change neither the outputs nor the count.
- R8: `los_i` = 1 while locked drops lock at the next edge. While unlocked, it has no effect.
- R9: `retry_cnt_o` increments by one on each drop of lock and holds at 2^RETRY_W-1 (7 by default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| freq_lock_i | input | 1 | Frequency lock reported by recovery loop |
| frame_vld_i | input | 1 | One-cycle strobe per received frame |
| bound_err_i | input | 1 | Frame not aligned to its boundary transition |
| flag_i | input | 1 | Received flag bit of the frame |
| flag_chk_en_i | input | 1 | Enable flag alternation check |
| los_i | input | 1 | Loss of signal |
| locked_o | output | 1 | Lock status |
| phase_mode_o | output | 1 | Detector mode: 1 phase, 0 frequency |
| src_data_o | output | 1 | Input source: 1 data stream, 0 reference clock |
| retry_cnt_o | output | RETRY_W | Saturating count of lock drops |

## Verification
The bench places a lone error between good frames and checks that lock survives. A design that failed to clear the count on a good frame would drop lock there. It sends an error strobe without `frame_vld_i` between two valid errors, so a design that sampled errors without the strobe would drop early. It repeats the flag with the check on and off, and it relocks right after a drop with one pending error, which exposes an error count that is not cleared on entry to acquisition. Enough drops are forced to reach the retry ceiling, where a wrapping counter would fall back to 0.

// File: rtl/rxlk_pkg.sv
package rxlk_pkg;
  typedef enum logic {
    ST_ACQ  = 1'b0,
    ST_LOCK = 1'b1
  } rxlk_state_e;
endpackage

// File: rtl/rxlk_frame_chk.sv
module rxlk_frame_chk (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  input  logic clr_i,
  input  logic frame_vld_i,
  input  logic bound_err_i,
  input  logic flag_i,
  input  logic flag_chk_en_i,
  output logic good_o,
  output logic bad_o
);
  logic prev_flag_q, prev_vld_q, eval, flag_rep;

  assign eval     = active_i & frame_vld_i;
  assign flag_rep = flag_chk_en_i & prev_vld_q & (flag_i == prev_flag_q);
  assign bad_o    = eval & (bound_err_i | flag_rep);
  assign good_o   = eval & ~(bound_err_i | flag_rep);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_flag_q <= 1'b0;
      prev_vld_q  <= 1'b0;
    end else if (clr_i) begin
      prev_vld_q  <= 1'b0;
    end else if (eval) begin
      prev_flag_q <= flag_i;
      prev_vld_q  <= 1'b1;
    end
  end
endmodule

// File: rtl/rxlk_err_cnt.sv
module rxlk_err_cnt #(
  parameter int unsigned ERR_LIMIT = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic good_i,
  input  logic bad_i,
  output logic limit_o
);
  localparam int unsigned CW = (ERR_LIMIT < 2) ? 1 : $clog2(ERR_LIMIT);
  logic [CW-1:0] cnt_q;

  assign limit_o = bad_i & (cnt_q == CW'(ERR_LIMIT - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clr_i || good_i)   cnt_q <= '0;
    else if (bad_i && !limit_o) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/rxlk_sat_cnt.sv
module rxlk_sat_cnt #(
  parameter int unsigned W = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] MAX = '1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_o <= '0;
    else if (inc_i && cnt_o != MAX) cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/rxlk_ctrl.sv
module rxlk_ctrl #(
  parameter int unsigned ERR_LIMIT = 2,
  parameter int unsigned RETRY_W   = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               freq_lock_i,
  input  logic               frame_vld_i,
  input  logic               bound_err_i,
  input  logic               flag_i,
  input  logic               flag_chk_en_i,
  input  logic               los_i,
  output logic               locked_o,
  output logic               phase_mode_o,
  output logic               src_data_o,
  output logic [RETRY_W-1:0] retry_cnt_o
);
  import rxlk_pkg::*;

  rxlk_state_e state_q, state_d;
  logic        in_lock, good, bad, limit_hit, drop;

  assign in_lock = (state_q == ST_LOCK);
  assign drop    = in_lock & (los_i | limit_hit);

  rxlk_frame_chk u_fchk (
    .clk_i, .rst_ni,
    .active_i      (in_lock),
    .clr_i         (drop),
    .frame_vld_i, .bound_err_i, .flag_i, .flag_chk_en_i,
    .good_o        (good),
    .bad_o         (bad)
  );

  rxlk_err_cnt #(.ERR_LIMIT(ERR_LIMIT)) u_ecnt (
    .clk_i, .rst_ni,
    .clr_i   (drop),
    .good_i  (good),
    .bad_i   (bad),
    .limit_o (limit_hit)
  );

  rxlk_sat_cnt #(.W(RETRY_W)) u_retry (
    .clk_i, .rst_ni,
    .inc_i (drop),
    .cnt_o (retry_cnt_o)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_ACQ:  if (freq_lock_i) state_d = ST_LOCK;
      ST_LOCK: if (drop)        state_d = ST_ACQ;
      default: state_d = ST_ACQ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_ACQ;
    else         state_q <= state_d;
  end

  // one state bit steers all three so they switch together
  assign locked_o     = in_lock;
  assign phase_mode_o = in_lock;
  assign src_data_o   = in_lock;
endmodule

// File: rtl/rxlk_ctrl_chk.sv
module rxlk_ctrl_chk #(
  parameter int unsigned ERR_LIMIT = 2,
  parameter int unsigned RETRY_W   = 3
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               freq_lock_i,
  input logic               frame_vld_i,
  input logic               bound_err_i,
  input logic               flag_i,
  input logic               flag_chk_en_i,
  input logic               los_i,
  input logic               locked_o,
  input logic               phase_mode_o,
  input logic               src_data_o,
  input logic [RETRY_W-1:0] retry_cnt_o
);
  localparam logic [RETRY_W-1:0] RMAX = '1;

  p_modes_agree_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_mode_o == locked_o) && (src_data_o == locked_o));

  p_lock_entry_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!locked_o && freq_lock_i) |=> locked_o);

  p_los_drop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (locked_o && los_i) |=> !locked_o);

  p_no_strobe_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (locked_o && !frame_vld_i && !los_i) |=> locked_o);

  p_clean_frame_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (locked_o && !los_i && !bound_err_i && !flag_chk_en_i) |=> locked_o);

  p_retry_inc_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(locked_o) && $past(retry_cnt_o) != RMAX) |-> retry_cnt_o == $past(retry_cnt_o) + 1'b1);

  p_retry_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$fell(locked_o) |-> $stable(retry_cnt_o));
endmodule

bind rxlk_ctrl rxlk_ctrl_chk #(.ERR_LIMIT(ERR_LIMIT), .RETRY_W(RETRY_W)) u_chk (.*);

// File: tb/sim_rxlk_ctrl.sv
`timescale 1ns/1ps
module sim_rxlk_ctrl;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic freq_lock_i = 0, frame_vld_i = 0, bound_err_i = 0, flag_i = 0, flag_chk_en_i = 0, los_i = 0;
  logic locked_o, phase_mode_o, src_data_o;
  logic [2:0] retry_cnt_o;

  int n_cmp = 0, n_bad = 0;
  int exp_retry = 0;
  logic [3:0] exp_q[$];
  string      tag_q[$];

  always #2 clk_i = ~clk_i;

  rxlk_ctrl u0 (.*);

  task automatic chk(input logic [3:0] act, input logic [3:0] exp, input string tag);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got lk/ph/src/retry=%b/%b/%b/%0d expected %b/%b/%b/%0d",
               tag, act[3], act[2], act[1], act[0], exp[3], exp[2], exp[1], exp[0]);
    end
  endtask

  // monitor: compares state after each edge against queued expectation
  always @(posedge clk_i) begin
    #1;
    if (exp_q.size() > 0) begin
      logic [3:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_cmp++;
      if ({locked_o, phase_mode_o, src_data_o} !== {3{e[3]}} || retry_cnt_o !== e[2:0]) begin
        n_bad++;
        $display("FAIL %s: got lk/ph/src=%b%b%b retry=%0d expected lk=%b retry=%0d",
                 t, locked_o, phase_mode_o, src_data_o, retry_cnt_o, e[3], e[2:0]);
      end
    end
  end

  task automatic s(input logic fl, fv, be, fg, fce, ls, exp_lk, input string tag);
    @(negedge clk_i);
    freq_lock_i = fl; frame_vld_i = fv; bound_err_i = be;
    flag_i = fg; flag_chk_en_i = fce; los_i = ls;
    exp_q.push_back({exp_lk, 3'(exp_retry)});
    tag_q.push_back(tag);
  endtask

  function automatic void drop();
    if (exp_retry < 7) exp_retry++;
  endfunction

  initial begin
    fork
      begin
        repeat (50000) @(posedge clk_i);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
      end
      begin
        repeat (3) @(posedge clk_i);
        #1 chk({locked_o, phase_mode_o, src_data_o, 1'b0} | {3'b0, |retry_cnt_o}, 4'b0000, "R1 in reset");
        @(negedge clk_i) rst_ni = 1'b1;
        s(0,0,0,0,0,0,0,"R1 idle after reset");
        s(0,1,1,0,0,0,0,"R7 frames ignored in acq");
        s(0,1,1,0,0,0,0,"R7 frames ignored in acq 2");
        s(0,0,0,0,0,1,0,"R8 los ignored in acq");
        s(1,0,0,0,0,0,1,"R2 lock entry");
        s(1,0,0,0,0,0,1,"R2 freq lock ignored while locked");
        s(0,1,0,0,0,0,1,"R4 good frame");
        s(0,1,1,0,0,0,1,"R5 single error");
        s(0,1,0,0,0,0,1,"R5 good after error");
        s(0,1,1,0,0,0,1,"R6 count restarted by good frame");
        s(0,0,1,0,0,0,1,"R7 error without strobe");
        drop();
        s(0,1,1,0,0,0,0,"R4 two consecutive errors drop");
        s(1,0,0,0,0,0,1,"R2 relock");
        s(0,1,0,0,1,0,1,"R3 alternating 0");
        s(0,1,0,1,1,0,1,"R3 alternating 1");
        s(0,1,0,0,1,0,1,"R3 alternating 0b");
        s(0,1,0,1,1,0,1,"R3 alternating 1b");
        s(0,1,0,1,1,0,1,"R3 one repeated flag");
        s(0,1,0,0,1,0,1,"R3 alternation resumes");
        s(0,1,0,0,1,0,1,"R3 repeat again");
        drop();
        s(0,1,0,0,1,0,0,"R3 two repeats drop");
        s(1,0,0,0,1,0,1,"R2 relock 2");
        s(0,1,0,1,1,0,1,"R3 first frame has no predecessor");
        s(0,1,0,1,0,0,1,"R3 check disabled repeat");
        s(0,1,0,1,0,0,1,"R3 check disabled repeat 2");
        s(0,1,1,0,0,0,1,"R6 one pending error");
        drop();
        s(0,0,0,0,0,1,0,"R8 los drops lock");
        s(1,0,0,0,0,0,1,"R2 relock 3");
        s(0,1,1,0,0,0,1,"R6 count cleared on acq entry");
        s(0,1,0,0,0,0,1,"R6 good");
        for (int i = 0; i < 8; i++) begin
          s(1,0,0,0,0,0,1,"R9 relock");
          drop();
          s(0,0,0,0,0,1,0,"R9 retry count");
        end
        s(0,0,0,0,0,0,0,"R9 saturated hold");
        @(negedge clk_i);
        @(negedge clk_i);
      end
    join_any
    disable fork;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule